// File: doc/BRIEF.md
# Two-Channel Serial Converter Interface Controller

This block is the digital side of a small 12-bit successive-approximation converter with a three-wire serial port. A host lowers an active-low select line to wake the converter and start a conversion. It then toggles a serial clock, and the result comes back as a 16-bit frame on a serial data line. That line is driven only while the select line is low. The analog front end is replaced by a parallel result port, `conv_data_i`. A start pulse and a channel indication tell the converter stub when to sample and which input to sample.

The serial clock level at the moment select falls picks one of two pacing modes:

- **Externally paced:** the host's serial clock also paces the conversion.
- **Internally paced:** an on-chip conversion delay is modelled as a fixed number of system-clock cycles. When it ends, the data line rises to flag completion, and the host can read the frame at any speed.

A configuration input selects between two input arrangements. With two single-ended inputs, the controller alternates channels on every deselection. With one pseudo-differential pair, the channel-ID bit always reads 1.

Select and serial clock arrive asynchronously. Both are brought into the system clock domain through a synchronizer, and their edges are detected there.

Top module: `sadc_if_ctrl`

## Requirements
- R1: Pacing mode selection on a falling edge of `cs_n_i`:
  - If `sclk_i` is high, the internally paced mode is chosen, and the first later `sclk_i` fall raises `conv_start_o`.
  - If `sclk_i` is low, the externally paced mode is chosen.
- R2: A frame is 16 bits, placed on `sdo_o` one bit per `sclk_i` fall, in this order: bits 1 to 3 are 1, bit 4 is the channel ID, and bits 5 to 16 are the captured result from bit 11 down to bit 0.
- R3: In externally paced mode:
  - fall k of `sclk_i` presents frame bit k;
  - the second fall raises `conv_start_o` for exactly one cycle;
  - the second fall captures `conv_data_i`.
- R4: In internally paced mode:
  - `sdo_o` stays 0 for `CONV_LAT` system cycles after the sampling fall;
  - `sclk_i` falls during that time are ignored;
  - `sdo_o` then rises as the completion flag (frame bit 1), and each later fall presents the next frame bit, starting at bit 2.
- R5: `sdo_o` changes only in these cases: after a detected `sclk_i` fall, after the end of an internal conversion, or after deselection. `sdo_oe_o` is 0 no later than four system cycles after `cs_n_i` goes high, and stays 0 while it is high.
- R6: Once bit 16 has been sent, further `sclk_i` falls with `cs_n_i` low present 0.
- R7: Channel sequence in two-input mode (`pdiff_i` = 0):
  - the first selection after reset uses channel 0 (ID bit 0, `conv_ch_o` = 0);
  - every rise of `cs_n_i` swaps to the other channel, whether or not a frame was completed;
  - so a select pulse with no clocks repeats the previous channel.
- R8: With `pdiff_i` = 1, the channel-ID bit is 1 and `conv_ch_o` is 0.
- R9: A rise of `cs_n_i` before a conversion or frame completes does the following:
  - it returns the block to shutdown;
  - no completion flag appears;
  - the next selection starts a fresh frame at bit 1.
- R10: While `rst_n` is low, and with `cs_n_i` high, `sdo_o`, `sdo_oe_o` and `conv_start_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Active-low select; high means shutdown (asynchronous) |
| sclk_i | input | 1 | Serial clock from host (asynchronous) |
| pdiff_i | input | 1 | 1 = single pseudo-differential pair, 0 = two single-ended inputs |
| conv_data_i | input | DATA_W | Result from the converter stub |
| conv_start_o | output | 1 | One-cycle pulse at the sampling instant |
| conv_ch_o | output | 1 | Channel to be sampled |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Drive enable for the serial data pad |

## Verification
The frame path is tried with several result patterns:

- alternating-bit words, which expose bit-order and off-by-one slips;
- a lone MSB and a lone LSB, which pin down the two ends of the data field;
- all ones and all zeros, which separate the data field from the leading ones and the trailing zeros.

Each frame is run in both pacing modes. The fall on which the start pulse appears tells the two modes apart. Internal frames carry an extra clock pulse during the conversion to prove it is ignored. Aborts in both modes, and an empty select pulse, are followed by full frames. Those frames show that channel alternation counts deselections and that every new frame restarts at bit 1. A last pair of frames in pseudo-differential mode separates a fixed ID bit from the alternating one.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    // Controller phases
    typedef enum logic [2:0] {
        ST_SHDN,      // deselected, output off
        ST_EXT,       // host clock paces conversion and frame
        ST_INT_WAIT,  // internal pacing, waiting for sampling fall
        ST_INT_CONV,  // internal conversion running
        ST_INT_READ   // internal result being shifted out
    } ctrl_st_e;

    // Bit positions in the synchronized input vector
    localparam int SYNC_SCLK = 0;
    localparam int SYNC_CS   = 1;
    localparam int SYNC_W    = 2;

endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
    parameter int              WIDTH   = 2,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] lvl_o,   // synchronized level
    output logic [WIDTH-1:0] prev_o   // level one cycle earlier
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
        logic [WIDTH-1:0]             prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.prev = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.chain <= {STAGES{RST_VAL}};
            s_q.prev  <= RST_VAL;
        end else begin
            s_q <= s_d;
        end
    end

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            assign lvl_o[g]  = s_q.chain[STAGES-1][g];
            assign prev_o[g] = s_q.prev[g];
        end
    endgenerate

endmodule

// File: rtl/sadc_lat_timer.sv
module sadc_lat_timer #(
    parameter int CONV_LAT = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic clear_i,
    output logic done_o
);

    localparam int CNT_W = $clog2(CONV_LAT + 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d    = t_q;
        done_o = 1'b0;
        if (clear_i) begin
            t_d.run = 1'b0;
            t_d.cnt = '0;
        end else if (start_i) begin
            t_d.run = 1'b1;
            t_d.cnt = CNT_W'(CONV_LAT);
        end else if (t_q.run) begin
            if (t_q.cnt == CNT_W'(1)) begin
                done_o  = 1'b1;
                t_d.run = 1'b0;
                t_d.cnt = '0;
            end else begin
                t_d.cnt = t_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

endmodule

// File: rtl/sadc_if_ctrl.sv
module sadc_if_ctrl
    import sadc_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int LEAD_ONES   = 3,
    parameter int CONV_LAT    = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sclk_i,
    input  logic              pdiff_i,
    input  logic [DATA_W-1:0] conv_data_i,
    output logic              conv_start_o,
    output logic              conv_ch_o,
    output logic              sdo_o,
    output logic              sdo_oe_o
);

    localparam int FRAME_W     = LEAD_ONES + 1 + DATA_W;
    localparam int CHID_POS    = LEAD_ONES + 1;
    localparam int IDX_MAX     = FRAME_W + 1;
    localparam int IDX_W       = $clog2(IDX_MAX + 1);
    localparam int DIDX_W      = $clog2(DATA_W);
    localparam int SAMPLE_EDGE = 2;

    typedef struct packed {
        ctrl_st_e          st;
        logic [IDX_W-1:0]  idx;
        logic              dout;
        logic              oe;
        logic              chan;
        logic [DATA_W-1:0] data;
        logic              start;
    } regs_t;

    regs_t r_d, r_q;

    // Input synchronization and edge detection
    logic [SYNC_W-1:0] in_lvl, in_prev;
    logic cs_fall, cs_rise, sclk_fall, sclk_lvl;

    sadc_sync #(
        .WIDTH   (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_W'(1) << SYNC_CS)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n_i, sclk_i}),
        .lvl_o   (in_lvl),
        .prev_o  (in_prev)
    );

    assign cs_fall   = !in_lvl[SYNC_CS] &&  in_prev[SYNC_CS];
    assign cs_rise   =  in_lvl[SYNC_CS] && !in_prev[SYNC_CS];
    assign sclk_fall = !in_lvl[SYNC_SCLK] && in_prev[SYNC_SCLK];
    assign sclk_lvl  =  in_lvl[SYNC_SCLK];

    // Internal conversion delay
    logic tmr_start, tmr_done;

    sadc_lat_timer #(
        .CONV_LAT (CONV_LAT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .clear_i (cs_rise),
        .done_o  (tmr_done)
    );

    // Frame bit k (1-based); 0 outside the frame
    function automatic logic frame_bit(input logic [IDX_W-1:0] k,
                                       input logic chid,
                                       input logic [DATA_W-1:0] word);
        logic b;
        int   ki;
        ki = int'(k);
        b  = 1'b0;
        if (ki >= 1 && ki <= LEAD_ONES) begin
            b = 1'b1;
        end else if (ki == CHID_POS) begin
            b = chid;
        end else if (ki > CHID_POS && ki <= FRAME_W) begin
            b = word[DIDX_W'(FRAME_W - ki)];
        end
        return b;
    endfunction

    logic             chid;
    logic [IDX_W-1:0] idx_next;

    always_comb begin
        chid     = pdiff_i ? 1'b1 : r_q.chan;
        idx_next = (r_q.idx == IDX_W'(IDX_MAX)) ? r_q.idx : r_q.idx + IDX_W'(1);
    end

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        tmr_start = 1'b0;

        if (cs_rise) begin
            r_d.st   = ST_SHDN;
            r_d.oe   = 1'b0;
            r_d.dout = 1'b0;
            r_d.idx  = '0;
            r_d.chan = ~r_q.chan;
        end else begin
            unique case (r_q.st)
                ST_SHDN: begin
                    if (cs_fall) begin
                        r_d.oe   = 1'b1;
                        r_d.dout = 1'b0;
                        r_d.idx  = '0;
                        r_d.st   = sclk_lvl ? ST_INT_WAIT : ST_EXT;
                    end
                end
                ST_EXT: begin
                    if (sclk_fall) begin
                        r_d.idx = idx_next;
                        if (idx_next == IDX_W'(SAMPLE_EDGE)) begin
                            r_d.start = 1'b1;
                            r_d.data  = conv_data_i;
                        end
                        r_d.dout = frame_bit(idx_next, chid, r_d.data);
                    end
                end
                ST_INT_WAIT: begin
                    if (sclk_fall) begin
                        r_d.start = 1'b1;
                        tmr_start = 1'b1;
                        r_d.st    = ST_INT_CONV;
                    end
                end
                ST_INT_CONV: begin
                    if (tmr_done) begin
                        r_d.data = conv_data_i;
                        r_d.idx  = IDX_W'(1);
                        r_d.dout = frame_bit(IDX_W'(1), chid, conv_data_i);
                        r_d.st   = ST_INT_READ;
                    end
                end
                ST_INT_READ: begin
                    if (sclk_fall) begin
                        r_d.idx  = idx_next;
                        r_d.dout = frame_bit(idx_next, chid, r_q.data);
                    end
                end
                default: r_d.st = ST_SHDN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_SHDN;
        end else begin
            r_q <= r_d;
        end
    end

    assign conv_start_o = r_q.start;
    assign conv_ch_o    = pdiff_i ? 1'b0 : r_q.chan;
    assign sdo_o        = r_q.dout;
    assign sdo_oe_o     = r_q.oe;

endmodule

// File: rtl/sadc_if_ctrl_chk.sv
module sadc_if_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n_i,
    input logic cs_fall,
    input logic cs_rise,
    input logic sclk_fall,
    input logic tmr_done,
    input logic conv_start_o,
    input logic sdo_o,
    input logic sdo_oe_o
);

    assert_sdo_moves_on_events_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_o) |-> $past(sclk_fall || tmr_done || cs_rise || cs_fall));

    assert_off_when_deselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && $past(cs_n_i, 1) && $past(cs_n_i, 2) && $past(cs_n_i, 3)
         && $past(cs_n_i, 4)) |-> !sdo_oe_o);

    assert_start_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);

    assert_start_only_selected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> sdo_oe_o);

    assert_eoc_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_done |=> (sdo_o && sdo_oe_o));

endmodule

bind sadc_if_ctrl sadc_if_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n_i       (cs_n_i),
    .cs_fall      (cs_fall),
    .cs_rise      (cs_rise),
    .sclk_fall    (sclk_fall),
    .tmr_done     (tmr_done),
    .conv_start_o (conv_start_o),
    .sdo_o        (sdo_o),
    .sdo_oe_o     (sdo_oe_o)
);

// File: tb/sadc_if_ctrl_bench.sv
module sadc_if_ctrl_bench;

    localparam int DW   = 12;
    localparam int LAT  = 40;
    localparam int FW   = 16;
    localparam int HALF = 10; // system cycles per serial clock phase

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sclk = 1'b0;
    logic          pdiff = 1'b0;
    logic [DW-1:0] cdata = '0;
    logic          conv_start, conv_ch, sdo, sdo_oe;

    always #5 clk = ~clk;

    sadc_if_ctrl #(
        .DATA_W   (DW),
        .LEAD_ONES(3),
        .CONV_LAT (LAT),
        .SYNC_STAGES(2)
    ) u_sadc_if_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n_i       (cs_n),
        .sclk_i       (sclk),
        .pdiff_i      (pdiff),
        .conv_data_i  (cdata),
        .conv_start_o (conv_start),
        .conv_ch_o    (conv_ch),
        .sdo_o        (sdo),
        .sdo_oe_o     (sdo_oe)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int n_starts = 0;
    int fall_no  = 0;
    int start_fall = -1;
    logic start_ch = 1'b0;
    logic exp_ch   = 1'b0;
    bit   finished = 1'b0;

    always @(posedge clk) begin
        if (conv_start) begin
            n_starts   <= n_starts + 1;
            start_fall <= fall_no;
            start_ch   <= conv_ch;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    function automatic logic exp_bit(input int k, input logic chid, input logic [DW-1:0] w);
        if (k >= 1 && k <= 3) return 1'b1;
        if (k == 4) return chid;
        if (k >= 5 && k <= FW) return w[FW - k];
        return 1'b0;
    endfunction

    task automatic sel(input logic lvl);
        sclk = lvl;
        wclk(4);
        cs_n = 1'b0;
        fall_no = 0;
        wclk(8);
    endtask

    task automatic desel();
        cs_n = 1'b1;
        wclk(8);
        exp_ch = ~exp_ch;
        check("R5 output off after deselect", int'(sdo_oe), 0);
    endtask

    // one pulse ending in a fall; samples 8 cycles after the fall
    task automatic pulse();
        sclk = 1'b1;
        wclk(HALF);
        sclk = 1'b0;
        fall_no++;
        wclk(8);
    endtask

    task automatic t_reset();
        wclk(3);
        check("R10 reset sdo", int'(sdo), 0);
        check("R10 reset oe", int'(sdo_oe), 0);
        check("R10 reset start", int'(conv_start), 0);
        rst_n = 1'b1;
        wclk(4);
    endtask

    task automatic t_ext(input logic [DW-1:0] w, input int extra);
        int   s0;
        logic chid;
        cdata = w;
        chid  = pdiff ? 1'b1 : exp_ch;
        s0    = n_starts;
        sel(1'b0);
        check("R1 ext enable", int'(sdo_oe), 1);
        for (int k = 1; k <= FW + extra; k++) begin
            pulse();
            if (k <= FW) check("R2 R3 ext frame bit", int'(sdo), int'(exp_bit(k, chid, w)));
            else         check("R6 trailing zero", int'(sdo), 0);
            wclk(2);
        end
        check("R3 ext single start", n_starts - s0, 1);
        check("R3 ext start on second fall", start_fall, 2);
        if (pdiff) check("R8 pdiff channel", int'(start_ch), 0);
        else       check("R7 ext channel", int'(start_ch), int'(exp_ch));
        desel();
    endtask

    task automatic t_int(input logic [DW-1:0] w, input int extra);
        int   s0;
        logic chid;
        cdata = w;
        chid  = pdiff ? 1'b1 : exp_ch;
        s0    = n_starts;
        sel(1'b1);
        check("R4 int low before sample", int'(sdo), 0);
        sclk = 1'b0;
        fall_no = 1;
        wclk(8);
        check("R1 int start on first fall", start_fall, 1);
        check("R4 int low while converting", int'(sdo), 0);
        sclk = 1'b1;
        wclk(3);
        sclk = 1'b0;
        fall_no++;
        wclk(8);
        check("R4 fall during conversion ignored", int'(sdo), 0);
        check("R4 no second start", n_starts - s0, 1);
        wclk(LAT);
        check("R4 completion flag", int'(sdo), 1);
        for (int k = 2; k <= FW + extra; k++) begin
            pulse();
            if (k <= FW) check("R2 R4 int frame bit", int'(sdo), int'(exp_bit(k, chid, w)));
            else         check("R6 trailing zero", int'(sdo), 0);
            wclk(2);
        end
        if (pdiff) check("R8 pdiff channel", int'(start_ch), 0);
        else       check("R7 int channel", int'(start_ch), int'(exp_ch));
        desel();
    endtask

    task automatic t_abort_int();
        sel(1'b1);
        sclk = 1'b0;
        wclk(12);
        desel();
        wclk(LAT + 10);
        check("R9 no flag after abort", int'(sdo), 0);
        check("R9 off after abort", int'(sdo_oe), 0);
    endtask

    task automatic t_abort_ext();
        cdata = 12'h0F0;
        sel(1'b0);
        for (int k = 1; k <= 3; k++) begin
            pulse();
            wclk(2);
        end
        desel();
        check("R9 off after ext abort", int'(sdo), 0);
    endtask

    task automatic t_empty_select();
        sel(1'b0);
        desel();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        t_reset();
        t_ext(12'hA5C, 3);     // R7 channel 0 first, R6 trailing zeros
        t_int(12'h3F1, 0);     // channel 1
        t_ext(12'h800, 0);     // channel 0, lone MSB
        t_int(12'h001, 2);     // channel 1, lone LSB
        t_abort_int();         // consumes channel 0
        t_ext(12'hFFF, 0);     // R9 fresh frame, channel 1
        t_abort_ext();         // consumes channel 0
        t_ext(12'h000, 1);     // channel 1
        t_empty_select();      // R7 empty select swaps channel
        t_int(12'h5A3, 0);     // channel 1 again
        pdiff = 1'b1;
        t_ext(12'h6B2, 0);     // R8
        t_int(12'h9C4, 0);     // R8
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule